// File: doc/BRIEF.md
# Per-Channel Reassembly Aging Scanner

This block ages partly reassembled packets in an ATM receive engine. It does not run a timer for every virtual channel. A single programmable interval counter raises an aging request. Each request lets exactly one path/channel pair be examined, and this happens before the cell processor may take its next queued cell. The scanner keeps a path index, a channel index and a pass counter, and uses them to sweep through a path-indexed pointer table. An enabled pointer entry gives a base address and a maximum channel number. The base plus the channel index selects one receive state entry. If that entry is ageable, its timeout count is incremented and written back. When the new count equals the entry's limit, the scanner issues a timeout request to the downstream end-of-packet logic.

The per-channel timeout is the clock period × interval register × pass-limit register × entry limit. Both tables are external synchronous RAMs: read data is valid the cycle after the read strobe.

The controller is a state machine with these states. S_IDLE goes to S_PREP when a request is pending, a cell is ready and the scanner is not halted. S_PREP updates the indices. It returns to S_IDLE on a halt and otherwise goes to S_PTR_RD. S_PTR_RD issues the pointer read and goes to S_PTR_CHK. S_PTR_CHK goes to S_ST_RD if the pointer entry is enabled and to S_FINISH if it is not. S_ST_RD issues the state read and goes to S_ST_CHK. S_ST_CHK goes to S_TMO on a limit hit and to S_FINISH otherwise. S_TMO pulses the timeout request and goes to S_TMO_WAIT. S_TMO_WAIT goes to S_FINISH on acknowledge. S_FINISH advances the channel and the pass counter and returns to S_IDLE.

Top module: `chan_age_scan`

## Requirements
- R1: The interval counter raises the pending request every `tick_interval` cycles (0 acts as 1). The first request is registered on the `tick_interval`-th clock edge after reset is released.
- R2: `cell_go` is high only in idle when no request is pending, or when the scanner is halted. A step starts only when `cell_ready` is high, and starting a step clears the pending request.
- R3: Every step that is not halted issues exactly one pointer read, at the current path index. Paths are visited in rising order from 0.
- R4: A pointer entry whose enable bit is clear ends the step with no state-table read or write, and the path advances at the next step.
- R5: For an enabled pointer entry, the state address read is the entry's base plus the channel index.
- R6: A state entry is aged only if it is active, is not waiting for end of packet, and has mode 2'b00 (AAL5 packet) or 2'b01 (PTI-delimited transparent packet). Modes 2'b10 and 2'b11 are never aged.
- R7: For an aged entry, count+1 is written back to the same address.
- R8: If count+1 equals the entry limit, `tmo_valid` pulses for one cycle carrying the state address. The step completes, and `cell_go` can return high, only after `tmo_ack`.
- R9: At the end of a step the channel index increments. If the pointer was disabled, or the old channel was at or above its maximum channel, the next step moves to the next path at channel 0.
- R10: The pass counter increments at the end of every step. When it equals `pass_limit` as a step starts, path, channel and pass counter all return to 0.
- R11: If a step starts while a path advance is due, the path index is at its maximum and the pass counter is not equal to `pass_limit`, the scanner halts. While halted it makes no table access and does not hold back cells.
- R12: An `age_restart` pulse zeroes path, channel and pass counter and leaves the halted state.
- R13: Reset gives idle with `cell_go` high and every strobe and request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_interval | input | TICK_W | Cycles between aging requests |
| pass_limit | input | PASS_W | Steps per sweep before the path index wraps to 0 |
| age_restart | input | 1 | Pulse that zeroes the indices and leaves the halted state |
| cell_ready | input | 1 | Cell processor wants to take the next cell |
| cell_go | output | 1 | Cell processor may proceed |
| ptr_rd_en | output | 1 | Pointer-table read strobe |
| ptr_rd_addr | output | PATH_W | Pointer-table address (path index) |
| ptr_enable | input | 1 | Read data: entry enable |
| ptr_base | input | ADDR_W | Read data: state-table base address |
| ptr_max_chan | input | CHAN_W | Read data: highest valid channel |
| st_rd_en | output | 1 | State-table read strobe |
| st_addr | output | ADDR_W | State-table address for read and write |
| st_active | input | 1 | Read data: entry in use |
| st_wait_eop | input | 1 | Read data: waiting for end of packet |
| st_mode | input | 2 | Read data: mode code |
| st_count | input | CNT_W | Read data: timeout count |
| st_limit | input | CNT_W | Read data: timeout limit |
| st_wr_en | output | 1 | Count write-back strobe |
| st_wr_count | output | CNT_W | Count value written |
| tmo_valid | output | 1 | Timeout request pulse |
| tmo_addr | output | ADDR_W | State address of the timed-out entry |
| tmo_ack | input | 1 | Downstream end-of-packet logic accepted the request |

## Verification
Some properties are checked on every cycle. A pending request must hold back `cell_go`. The timeout pulse lasts one cycle, and each step issues one pointer read. A disabled pointer entry produces no state access. A halted scanner stays silent. A restart or a pass wrap zeroes the indices, and an interval expiry always sets the pending flag. Other behaviour only the bench scenarios can show: the order of visited paths, the address arithmetic, the counts written back, which entries qualify, and the exact cycle of the first request. The same applies to how a full sweep ends in a halt and how a restart resumes scanning at path 0.

// File: rtl/age_scan_pkg.sv
package age_scan_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREP,
        S_PTR_RD,
        S_PTR_CHK,
        S_ST_RD,
        S_ST_CHK,
        S_TMO,
        S_TMO_WAIT,
        S_FINISH
    } scan_state_e;

    localparam logic [1:0] MODE_AAL5 = 2'b00;
    localparam logic [1:0] MODE_PTI  = 2'b01;
    localparam logic [1:0] MODE_CELL = 2'b10;
    localparam logic [1:0] MODE_RAW  = 2'b11;

    function automatic logic mode_ageable(input logic [1:0] m);
        return (m == MODE_AAL5) || (m == MODE_PTI);
    endfunction

endpackage

// File: rtl/age_tick.sv
module age_tick #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] interval,
    input  logic              take,
    output logic              pending
);
    localparam int EXT_W = TICK_W + 1;

    logic [TICK_W-1:0] cnt_q;
    logic              tick_pulse;

    assign tick_pulse = (EXT_W'(cnt_q) + EXT_W'(1)) >= EXT_W'(interval);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else begin
            cnt_q <= tick_pulse ? '0 : cnt_q + 1'b1;
            if (tick_pulse)
                pending <= 1'b1;
            else if (take)
                pending <= 1'b0;
        end
    end

    // R1: an expired interval always leaves a pending request behind
    a_r1_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> pending);

endmodule

// File: rtl/age_index.sv
module age_index #(
    parameter int PATH_W = 12,
    parameter int CHAN_W = 10,
    parameter int PASS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              prep,
    input  logic              finish,
    input  logic              fin_adv,
    input  logic [PASS_W-1:0] pass_limit,
    output logic [PATH_W-1:0] path_idx,
    output logic [CHAN_W-1:0] chan_idx,
    output logic              halted,
    output logic              halt_now
);
    localparam logic [PATH_W-1:0] PATH_LAST = {PATH_W{1'b1}};

    logic [PASS_W-1:0] pass_cnt;
    logic              adv_q;
    logic              pass_wrap;

    assign pass_wrap = (pass_cnt == pass_limit);
    assign halt_now  = !pass_wrap && adv_q && (path_idx == PATH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_idx <= '0;
            chan_idx <= '0;
            pass_cnt <= '0;
            adv_q    <= 1'b0;
            halted   <= 1'b0;
        end else if (restart) begin
            path_idx <= '0;
            chan_idx <= '0;
            pass_cnt <= '0;
            adv_q    <= 1'b0;
            halted   <= 1'b0;
        end else if (prep) begin
            if (pass_wrap) begin
                path_idx <= '0;
                chan_idx <= '0;
                pass_cnt <= '0;
                adv_q    <= 1'b0;
            end else if (adv_q) begin
                if (path_idx == PATH_LAST) begin
                    halted <= 1'b1;
                end else begin
                    path_idx <= path_idx + 1'b1;
                    chan_idx <= '0;
                    adv_q    <= 1'b0;
                end
            end
        end else if (finish) begin
            pass_cnt <= pass_cnt + 1'b1;
            chan_idx <= chan_idx + 1'b1;
            if (fin_adv)
                adv_q <= 1'b1;
        end
    end

    // R12: restart zeroes the sweep position and leaves the halted state
    a_r12_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (path_idx == '0) && (chan_idx == '0) && !halted);

    // R10: a step starting at the pass limit begins a new sweep
    a_r10_pass_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (prep && !restart && pass_wrap) |=> (path_idx == '0) && (chan_idx == '0));

endmodule

// File: rtl/age_entry_eval.sv
module age_entry_eval
    import age_scan_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             active,
    input  logic             wait_eop,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    output logic             qualify,
    output logic [CNT_W-1:0] next_count,
    output logic             hit
);
    assign qualify    = active && !wait_eop && mode_ageable(mode);
    assign next_count = count + 1'b1;
    assign hit        = (next_count == limit);
endmodule

// File: rtl/chan_age_scan.sv
module chan_age_scan
    import age_scan_pkg::*;
#(
    parameter int PATH_W = 12,
    parameter int CHAN_W = 10,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int TICK_W = 16,
    parameter int PASS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick_interval,
    input  logic [PASS_W-1:0] pass_limit,
    input  logic              age_restart,
    input  logic              cell_ready,
    output logic              cell_go,
    output logic              ptr_rd_en,
    output logic [PATH_W-1:0] ptr_rd_addr,
    input  logic              ptr_enable,
    input  logic [ADDR_W-1:0] ptr_base,
    input  logic [CHAN_W-1:0] ptr_max_chan,
    output logic              st_rd_en,
    output logic [ADDR_W-1:0] st_addr,
    input  logic              st_active,
    input  logic              st_wait_eop,
    input  logic [1:0]        st_mode,
    input  logic [CNT_W-1:0]  st_count,
    input  logic [CNT_W-1:0]  st_limit,
    output logic              st_wr_en,
    output logic [CNT_W-1:0]  st_wr_count,
    output logic              tmo_valid,
    output logic [ADDR_W-1:0] tmo_addr,
    input  logic              tmo_ack
);
    localparam int CHAN_PAD = ADDR_W - CHAN_W;

    scan_state_e       state, nxt;
    logic              pending, halted, halt_now, start;
    logic              qualify, hit;
    logic [CNT_W-1:0]  next_count;
    logic [PATH_W-1:0] path_idx;
    logic [CHAN_W-1:0] chan_idx;
    logic [ADDR_W-1:0] addr_q;
    logic              fin_adv_q;

    assign start = pending && cell_ready && !halted;

    age_tick #(.TICK_W(TICK_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (tick_interval),
        .take     ((state == S_IDLE) && start),
        .pending  (pending)
    );

    age_index #(.PATH_W(PATH_W), .CHAN_W(CHAN_W), .PASS_W(PASS_W)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (age_restart),
        .prep       (state == S_PREP),
        .finish     (state == S_FINISH),
        .fin_adv    (fin_adv_q),
        .pass_limit (pass_limit),
        .path_idx   (path_idx),
        .chan_idx   (chan_idx),
        .halted     (halted),
        .halt_now   (halt_now)
    );

    age_entry_eval #(.CNT_W(CNT_W)) u_eval (
        .active     (st_active),
        .wait_eop   (st_wait_eop),
        .mode       (st_mode),
        .count      (st_count),
        .limit      (st_limit),
        .qualify    (qualify),
        .next_count (next_count),
        .hit        (hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Address and advance capture from the pointer entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            fin_adv_q <= 1'b0;
        end else if (state == S_PTR_CHK) begin
            addr_q    <= ptr_base + {{CHAN_PAD{1'b0}}, chan_idx};
            fin_adv_q <= !ptr_enable || (chan_idx >= ptr_max_chan);
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = S_PREP;
            S_PREP:     nxt = halt_now ? S_IDLE : S_PTR_RD;
            S_PTR_RD:   nxt = S_PTR_CHK;
            S_PTR_CHK:  nxt = ptr_enable ? S_ST_RD : S_FINISH;
            S_ST_RD:    nxt = S_ST_CHK;
            S_ST_CHK:   nxt = (qualify && hit) ? S_TMO : S_FINISH;
            S_TMO:      nxt = S_TMO_WAIT;
            S_TMO_WAIT: if (tmo_ack) nxt = S_FINISH;
            S_FINISH:   nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cell_go     = (state == S_IDLE) && !(pending && !halted);
        ptr_rd_en   = (state == S_PTR_RD);
        ptr_rd_addr = path_idx;
        st_rd_en    = (state == S_ST_RD);
        st_addr     = addr_q;
        st_wr_en    = (state == S_ST_CHK) && qualify;
        st_wr_count = next_count;
        tmo_valid   = (state == S_TMO);
        tmo_addr    = addr_q;
    end

    // R8: timeout request lasts a single cycle
    a_r8_tmo_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_valid |=> !tmo_valid);

    // R2: a pending request holds back the cell processor
    a_r2_go_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !halted) |-> !cell_go);

    // R3: one pointer read per step
    a_r3_single_ptr_read: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd_en |=> !ptr_rd_en);

    // R4: a disabled pointer entry causes no state access
    a_r4_disabled_no_state: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_PTR_CHK) && !ptr_enable) |=> (!st_rd_en && !st_wr_en));

    // R11: a halted scanner touches neither table
    a_r11_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!ptr_rd_en && !st_rd_en && !st_wr_en));

endmodule

// File: tb/chan_age_scan_bench.sv
`timescale 1ns/1ps
module chan_age_scan_bench;
    localparam int PATH_W = 3;
    localparam int CHAN_W = 4;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;
    localparam int TICK_W = 8;
    localparam int PASS_W = 8;
    localparam int NPATH  = 1 << PATH_W;
    localparam int NST    = 1 << ADDR_W;

    typedef struct {
        byte kind;
        int  addr;
        int  val;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TICK_W-1:0] tick_interval = 8'd20;
    logic [PASS_W-1:0] pass_limit = 8'd4;
    logic age_restart = 1'b0;
    logic cell_ready = 1'b0;
    logic tmo_ack = 1'b0;
    logic cell_go, ptr_rd_en, st_rd_en, st_wr_en, tmo_valid;
    logic [PATH_W-1:0] ptr_rd_addr;
    logic [ADDR_W-1:0] st_addr, tmo_addr;
    logic [CNT_W-1:0]  st_wr_count;
    logic              ptr_enable;
    logic [ADDR_W-1:0] ptr_base;
    logic [CHAN_W-1:0] ptr_max_chan;
    logic              st_active, st_wait_eop;
    logic [1:0]        st_mode;
    logic [CNT_W-1:0]  st_count, st_limit;

    logic              pm_en   [NPATH];
    logic [ADDR_W-1:0] pm_base [NPATH];
    logic [CHAN_W-1:0] pm_max  [NPATH];
    logic              sm_act  [NST];
    logic              sm_eop  [NST];
    logic [1:0]        sm_mode [NST];
    logic [CNT_W-1:0]  sm_cnt  [NST];
    logic [CNT_W-1:0]  sm_lim  [NST];

    ev_t exp_q[$];
    int  total = 0;
    int  failed = 0;
    int  p_seen = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    chan_age_scan #(
        .PATH_W(PATH_W), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .TICK_W(TICK_W), .PASS_W(PASS_W)
    ) u_chan_age_scan (
        .clk(clk), .rst_n(rst_n), .tick_interval(tick_interval),
        .pass_limit(pass_limit), .age_restart(age_restart),
        .cell_ready(cell_ready), .cell_go(cell_go),
        .ptr_rd_en(ptr_rd_en), .ptr_rd_addr(ptr_rd_addr),
        .ptr_enable(ptr_enable), .ptr_base(ptr_base), .ptr_max_chan(ptr_max_chan),
        .st_rd_en(st_rd_en), .st_addr(st_addr), .st_active(st_active),
        .st_wait_eop(st_wait_eop), .st_mode(st_mode), .st_count(st_count),
        .st_limit(st_limit), .st_wr_en(st_wr_en), .st_wr_count(st_wr_count),
        .tmo_valid(tmo_valid), .tmo_addr(tmo_addr), .tmo_ack(tmo_ack)
    );

    // Synchronous table models
    always @(posedge clk) begin
        if (ptr_rd_en) begin
            ptr_enable   <= pm_en[ptr_rd_addr];
            ptr_base     <= pm_base[ptr_rd_addr];
            ptr_max_chan <= pm_max[ptr_rd_addr];
        end
        if (st_rd_en) begin
            st_active   <= sm_act[st_addr];
            st_wait_eop <= sm_eop[st_addr];
            st_mode     <= sm_mode[st_addr];
            st_count    <= sm_cnt[st_addr];
            st_limit    <= sm_lim[st_addr];
        end
        if (st_wr_en) sm_cnt[st_addr] <= st_wr_count;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input byte k, input int a, input int v);
        ev_t e;
        e.kind = k; e.addr = a; e.val = v;
        exp_q.push_back(e);
    endtask

    task automatic observe(input byte k, input int a, input int v, input string tag);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, {tag, " unexpected event"}, a, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == k, {tag, " event kind"}, int'(k), int'(e.kind));
            check(e.addr == a, {tag, " address"}, a, e.addr);
            check(e.val == v, {tag, " value"}, v, e.val);
        end
    endtask

    // Monitor: compare every table access and request against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ptr_rd_en) begin
                p_seen++;
                observe("P", int'(ptr_rd_addr), 0, "R3 path order");
            end
            if (st_rd_en)  observe("R", int'(st_addr), 0, "R5 state address");
            if (st_wr_en)  observe("W", int'(st_addr), int'(st_wr_count), "R7 count write");
            if (tmo_valid) observe("T", int'(tmo_addr), 0, "R8 timeout request");
        end
    end

    // Downstream acknowledge with a hold-off; the step must not finish early (R8)
    initial begin
        forever begin
            @(negedge clk);
            if (tmo_valid) begin
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    check(!cell_go && !ptr_rd_en, "R8 step held until ack", int'(cell_go), 0);
                end
                tmo_ack = 1'b1;
                @(negedge clk);
                tmo_ack = 1'b0;
            end
        end
    end

    task automatic clear_tables();
        for (int i = 0; i < NPATH; i++) begin
            pm_en[i] = 1'b0; pm_base[i] = '0; pm_max[i] = '0;
        end
        for (int i = 0; i < NST; i++) begin
            sm_act[i] = 1'b0; sm_eop[i] = 1'b0; sm_mode[i] = 2'b00;
            sm_cnt[i] = '0;  sm_lim[i] = '0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cell_go && !ptr_rd_en && !st_rd_en && !st_wr_en && !tmo_valid,
              "R13 reset state", int'(cell_go), 1);
        rst_n = 1'b1;
    endtask

    task automatic wait_paths(input int n);
        while (p_seen < n) @(negedge clk);
    endtask

    // Driver
    initial begin
        // Scenario A: interval, blocking, qualification, timeout, pass wrap
        clear_tables();
        pm_en[0] = 1'b1; pm_base[0] = 8'h10; pm_max[0] = 4'd1;
        pm_en[2] = 1'b1; pm_base[2] = 8'h40; pm_max[2] = 4'd0;
        sm_act[8'h10] = 1'b1; sm_mode[8'h10] = 2'b00; sm_lim[8'h10] = 4'd2;
        sm_act[8'h11] = 1'b1; sm_mode[8'h11] = 2'b01; sm_eop[8'h11] = 1'b1; sm_lim[8'h11] = 4'd1;
        sm_act[8'h40] = 1'b1; sm_mode[8'h40] = 2'b10; sm_lim[8'h40] = 4'd1;
        tick_interval = 8'd20;
        pass_limit = 8'd4;
        cell_ready = 1'b0;
        do_reset();
        repeat (19) @(posedge clk);
        @(negedge clk);
        check(cell_go == 1'b1, "R1 no request before interval", int'(cell_go), 1);
        @(posedge clk);
        @(negedge clk);
        check(cell_go == 1'b0, "R1 R2 request blocks cells", int'(cell_go), 0);
        repeat (30) @(negedge clk);
        check(p_seen == 0, "R2 no step without cell_ready", p_seen, 0);

        // R4 R6 R9 R10 expectations
        push("P", 0, 0); push("R", 8'h10, 0); push("W", 8'h10, 1);
        push("P", 0, 0); push("R", 8'h11, 0);
        push("P", 1, 0);
        push("P", 2, 0); push("R", 8'h40, 0);
        push("P", 0, 0); push("R", 8'h10, 0); push("W", 8'h10, 2); push("T", 8'h10, 0);
        push("P", 0, 0); push("R", 8'h11, 0);
        push("P", 1, 0);
        push("P", 2, 0); push("R", 8'h40, 0);
        push("P", 0, 0); push("R", 8'h10, 0); push("W", 8'h10, 3);
        cell_ready = 1'b1;
        wait_paths(9);
        cell_ready = 1'b0;
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R10 sweep events all seen", exp_q.size(), 0);
        check(sm_cnt[8'h10] == 4'd3, "R7 stored count", int'(sm_cnt[8'h10]), 3);
        check(sm_cnt[8'h11] == 4'd0, "R6 waiting entry untouched", int'(sm_cnt[8'h11]), 0);
        check(sm_cnt[8'h40] == 4'd0, "R6 cell-mode entry untouched", int'(sm_cnt[8'h40]), 0);

        // Scenario B: full sweep of disabled paths ends in a halt, then restart
        clear_tables();
        tick_interval = 8'd4;
        pass_limit = 8'd100;
        p_seen = 0;
        do_reset();
        for (int p = 0; p < NPATH; p++) push("P", p, 0);
        cell_ready = 1'b1;
        wait_paths(NPATH);
        repeat (80) @(negedge clk);
        check(p_seen == NPATH, "R11 no step after halt", p_seen, NPATH);
        check(cell_go == 1'b1, "R11 halted scanner frees cells", int'(cell_go), 1);
        check(exp_q.size() == 0, "R4 disabled sweep events seen", exp_q.size(), 0);

        for (int p = 0; p < NPATH; p++) push("P", p, 0);
        age_restart = 1'b1;
        @(negedge clk);
        age_restart = 1'b0;
        wait_paths(2 * NPATH);
        repeat (80) @(negedge clk);
        check(p_seen == 2 * NPATH, "R12 restart resumes at path 0", p_seen, 2 * NPATH);
        check(exp_q.size() == 0, "R12 restart events seen", exp_q.size(), 0);
        cell_ready = 1'b0;
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule